// File: doc/BRIEF.md
# Shift-and-Negate Coefficient Product Table

The block answers, one clock after an address is presented, with the product of a programmable signed coefficient and a 4-bit unsigned address word (0 to 15). A plain table would hold sixteen words, one per address. This one keeps only the four odd multiples of the coefficient: one, three, five and seven times its value. Every other product is rebuilt from them. The address is split into three parts: a selected odd multiple, a left-shift count equal to the number of trailing zeros, and a flag for the upper half of the table.

For addresses above eight the block uses the mirror of the address about the midpoint. It forms the product for (16 − address), negates it in two's complement, and adds sixteen times the coefficient. Sixteen times the coefficient is the single-multiple word shifted four places. Address zero returns zero. Address eight is the single-multiple word shifted three places.

A new coefficient is loaded by raising the load strobe for one cycle. All four odd multiples are recomputed and written on that edge. The block is purely a datapath. A read has one cycle of latency, and there is no state machine.

Top module: `reduced_product_table`

## Requirements
- R1: While reset is asserted and after it is released, the product output is zero. Every stored multiple is zero, so before any load every address returns zero.
- R2: Storage is exactly four words, holding 1·C, 3·C, 5·C and 7·C for the loaded coefficient C. The odd addresses 1, 3, 5 and 7 return these words unshifted.
- R3: Address 0 returns zero for any coefficient.
- R4: Addresses 2, 4, 6 and 8 return the odd multiple of the address's odd part shifted left by its trailing-zero count. This gives 2·C, 4·C, 6·C and 8·C.
- R5: Addresses 9 to 15 return 16·C − (16 − address)·C. This equals address·C.
- R6: The product output is signed and has the coefficient width plus 5 bits. No address and coefficient pair overflows it, including the most negative coefficient at addresses 15 and 8 and the most positive coefficient at address 15.
- R7: The product for the address sampled at a rising edge appears on the output just after that edge. The latency is exactly one cycle.
- R8: When the load strobe is high at an edge, all four stored multiples take the new coefficient's values at that edge. A read sampled at the same edge returns the product of the old coefficient.
- R9: While the load strobe is low, the coefficient input has no effect on any product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_ld | input | 1 | Load strobe for a new coefficient |
| coef_in | input | CW (8) | Signed coefficient value |
| addr | input | 4 | Unsigned table address |
| prod_q | output | CW+5 (13) | Registered signed product addr·C |

## Verification
A coefficient load and a table read can both be sampled at the same edge. The bench provokes this by raising the load strobe with a new value while holding an address. It expects the output after that edge to carry the old coefficient's product, and the output one cycle later to carry the new coefficient's product at the same address. A second provocation changes the coefficient input while the strobe is low. A following read must still show the previously loaded coefficient.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
    // Decoded view of one table address.
    typedef struct packed {
        logic       is_zero;  // address 0
        logic       mirror;   // address 9..15: negate and add 16*C
        logic [1:0] odd_idx;  // which stored odd multiple (1,3,5,7 -> 0..3)
        logic [1:0] shamt;    // left-shift count (trailing zeros)
    } addr_dec_t;
endpackage

// File: rtl/rpt_addr_decode.sv
module rpt_addr_decode
    import rpt_pkg::*;
(
    input  logic [3:0] addr_i,
    output addr_dec_t  dec_o
);
    logic [3:0] folded;
    logic [3:0] odd_part;

    always_comb begin
        dec_o         = '0;
        dec_o.is_zero = (addr_i == 4'd0);
        dec_o.mirror  = addr_i[3] && (addr_i[2:0] != 3'd0);
        folded        = dec_o.mirror ? (4'd0 - addr_i) : addr_i;
        unique casez (folded)
            4'b???1: dec_o.shamt = 2'd0;
            4'b??10: dec_o.shamt = 2'd1;
            4'b?100: dec_o.shamt = 2'd2;
            4'b1000: dec_o.shamt = 2'd3;
            default: dec_o.shamt = 2'd0;
        endcase
        odd_part      = folded >> dec_o.shamt;
        dec_o.odd_idx = odd_part[2:1];
    end

    // R4 R5: rebuilt index must recreate the address (or its mirror)
    always_comb begin
        if (!dec_o.is_zero) begin
            p_decode_rebuild_r5: assert (
                (dec_o.mirror ? (5'd16 - (5'({dec_o.odd_idx, 1'b1}) << dec_o.shamt))
                              : (5'({dec_o.odd_idx, 1'b1}) << dec_o.shamt))
                == {1'b0, addr_i});
        end
    end
endmodule

// File: rtl/rpt_odd_store.sv
module rpt_odd_store #(
    parameter int CW = 8,
    localparam int SW = CW + 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_i,
    input  logic signed [CW-1:0] coef_i,
    output logic [3:0][SW-1:0]   words_o
);
    logic signed [SW-1:0] cx;
    logic [3:0][SW-1:0]   next_w;

    assign cx = SW'(coef_i);

    for (genvar g = 0; g < 4; g++) begin : g_mult
        if (g == 0) begin : g_one
            assign next_w[g] = cx;
        end else if (g == 3) begin : g_seven
            assign next_w[g] = (cx <<< 3) - cx;
        end else begin : g_three_five
            assign next_w[g] = (cx <<< g) + cx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            words_o <= '0;
        else if (ld_i)
            words_o <= next_w;
    end

    // R8: a load writes all four odd multiples at once
    for (genvar g = 0; g < 4; g++) begin : g_chk
        p_load_multiple_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ld_i |=> (int'($signed(words_o[g])) == (2*g+1) * int'($past(coef_i))));
    end

    // R9: no write without the strobe
    p_hold_words_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_i |=> $stable(words_o));
endmodule

// File: rtl/rpt_shift_negate.sv
module rpt_shift_negate
    import rpt_pkg::*;
#(
    parameter int CW = 8,
    localparam int SW = CW + 3,
    localparam int PW = CW + 5
) (
    input  logic [SW-1:0]        sel_word_i,
    input  logic [SW-1:0]        one_word_i,
    input  addr_dec_t            dec_i,
    output logic signed [PW-1:0] prod_o
);
    logic signed [PW-1:0] sel_x, one_x, shifted, signed_term, bias;

    always_comb begin
        sel_x       = PW'($signed(sel_word_i));
        one_x       = PW'($signed(one_word_i));
        shifted     = sel_x <<< dec_i.shamt;
        signed_term = dec_i.mirror ? -shifted : shifted;
        bias        = dec_i.mirror ? (one_x <<< 4) : '0;
        prod_o      = dec_i.is_zero ? '0 : (signed_term + bias);
    end
endmodule

// File: rtl/reduced_product_table.sv
module reduced_product_table #(
    parameter int CW = 8,
    localparam int SW = CW + 3,
    localparam int PW = CW + 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 coef_ld,
    input  logic signed [CW-1:0] coef_in,
    input  logic [3:0]           addr,
    output logic signed [PW-1:0] prod_q
);
    import rpt_pkg::*;

    addr_dec_t            dec;
    logic [3:0][SW-1:0]   words;
    logic signed [PW-1:0] prod_d;

    rpt_addr_decode u_dec (
        .addr_i (addr),
        .dec_o  (dec)
    );

    rpt_odd_store #(.CW(CW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_i    (coef_ld),
        .coef_i  (coef_in),
        .words_o (words)
    );

    rpt_shift_negate #(.CW(CW)) u_shn (
        .sel_word_i (words[dec.odd_idx]),
        .one_word_i (words[0]),
        .dec_i      (dec),
        .prod_o     (prod_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            prod_q <= '0;
        else
            prod_q <= prod_d;
    end

    // R3: address zero always yields zero
    p_zero_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 4'd0) |=> (prod_q == '0));

    // R4: midpoint equals eight times the single multiple held before the edge
    p_midpoint_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 4'd8) |=> (int'(prod_q) == 8 * int'($signed($past(words[0])))));

    // R5: top entry equals sixteen minus one single multiple
    p_top_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 4'd15) |=> (int'(prod_q) == 15 * int'($signed($past(words[0])))));
endmodule

// File: tb/test_reduced_product_table.sv
module test_reduced_product_table;
    localparam int CW = 8;
    localparam int PW = CW + 5;
    localparam int NV = 8;
    // Coefficients swept over every address.
    localparam logic signed [CW-1:0] COEFS [NV] = '{
        8'sd1, -8'sd1, 8'sd127, -8'sd128, 8'sd37, -8'sd90, 8'sd0, 8'sd85};

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 coef_ld = 1'b0;
    logic signed [CW-1:0] coef_in = '0;
    logic [3:0]           addr = '0;
    logic signed [PW-1:0] prod_q;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    reduced_product_table #(.CW(CW)) i_reduced_product_table (
        .clk, .rst_n, .coef_ld, .coef_in, .addr, .prod_q);

    task automatic check(input string req, input int expv);
        checks++;
        if (int'(prod_q) != expv) begin
            failures++;
            $display("FAIL %s addr=%0d actual=%0d expected=%0d", req, addr, int'(prod_q), expv);
        end
    endtask

    task automatic load(input logic signed [CW-1:0] c);
        @(negedge clk); coef_ld = 1'b1; coef_in = c;
        @(negedge clk); coef_ld = 1'b0;
    endtask

    // Drive address at a falling edge; result is present after the next rising edge.
    task automatic read(input logic [3:0] a, input int expv, input string req);
        addr = a;
        @(negedge clk);
        check(req, expv);
    endtask

    task automatic sweep(input logic signed [CW-1:0] c);
        load(c);
        for (int a = 0; a < 16; a++) begin
            string r;
            if (a == 0) r = "R3";
            else if (a == 1 || a == 3 || a == 5 || a == 7) r = "R2";
            else if (a < 9) r = "R4";
            else r = "R5";
            read(4'(a), a * int'(c), r);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 0);                 // in reset
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 0);
        read(4'd15, 0, "R1");           // nothing loaded yet
        read(4'd7, 0, "R1");

        for (int v = 0; v < NV; v++) sweep(COEFS[v]);

        for (int k = 0; k < 6; k++) sweep(CW'($urandom(32'(k + 11))));

        // R6: extremes of the output range
        load(-8'sd128);
        read(4'd15, -1920, "R6");
        read(4'd8, -1024, "R6");
        load(8'sd127);
        read(4'd15, 1905, "R6");

        // R7: back-to-back addresses, each one cycle later
        load(8'sd9);
        addr = 4'd3;
        @(negedge clk); check("R7", 27);
        addr = 4'd12;
        @(negedge clk); check("R7", 108);
        addr = 4'd9;
        @(negedge clk); check("R7", 81);

        // R8: load and read sampled at the same edge
        load(8'sd11);
        addr = 4'd5; coef_ld = 1'b1; coef_in = -8'sd6;
        @(negedge clk); check("R8", 55);
        coef_ld = 1'b0;
        @(negedge clk); check("R8", -30);
        addr = 4'd13;
        @(negedge clk); check("R8", -78);

        // R9: coefficient input ignored without strobe
        coef_in = 8'sd100;
        addr = 4'd6;
        @(negedge clk); check("R9", -36);
        coef_in = -8'sd77;
        addr = 4'd11;
        @(negedge clk); check("R9", -66);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hang expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule